// File: doc/BRIEF.md
# Frame-Rate Change Monitor

This block watches a frame clock (the left/right word clock of a serial audio link) from a free-running local clock. It measures the length of every frame in local-clock cycles, keeps a reference period, and decides when the incoming rate has really moved. A move counts only when it is sustained. A frame clock that goes quiet also counts. When either event happens, the block emits a one-cycle re-initialization pulse for the downstream rate estimator and filters. It then holds the data output disabled until enough frames have passed for the new path to settle.

The block also drives an active-low status pin. The pin is low only when the output is enabled and no external fault is raised. The first complete frame after any re-initialization becomes the new reference, so the block adapts to a new rate without any software.

Top module: `frame_rate_monitor`

## Requirements
- R1: While and right after reset, `oe` is 0, `status_n` is 1 and `reinit` is 0. No frame history survives reset.
- R2: `frame_clk` passes through a two-flop synchronizer. A period is the number of `clk` cycles between successive synchronized rising edges. The first complete period after reset or a re-initialization is stored as the reference.
- R3: A period deviates when its absolute difference from the reference is strictly greater than the reference shifted right by `DEV_SHIFT` (default: one sixteenth). A difference exactly equal to that amount does not deviate. Only `DEV_RUN` (default 8) consecutive deviating periods fire `reinit`. Any non-deviating period restarts the run.
- R4: With a valid reference, the clock is declared stopped after twice the reference period passes with no edge. With no reference, the limit is `STOP_TIMEOUT` cycles. A stop fires `reinit` once and does not fire again until a new edge arrives. The period counter saturates at the limit.
- R5: `oe` falls with `reinit` and stays 0 until `SETTLE` (default 162) complete periods have been measured after the re-initialization, the reference period included. `oe` rises on the edge that ends the last of them.
- R6: `status_n` equals `fault_in` OR NOT `oe`.
- R7: When the deviation that fires `reinit` lands on the same frame edge that would complete settling, the re-initialization wins and `oe` stays 0.
- R8: `reinit` is high for exactly one `clk` cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Frame clock to monitor, asynchronous to `clk` |
| fault_in | input | 1 | External fault/limit flag, forces status high |
| reinit | output | 1 | One-cycle re-initialization pulse |
| oe | output | 1 | Output data enable; data must be zero while low |
| status_n | output | 1 | Active-low ready status |

## Verification
The colliding pair is the eighth consecutive deviating period and the completion of the settling count. Both are decided on a single synchronized frame edge. The bench provokes this by running nominal frames after a stop event and switching to a wider period so that the eighth deviation falls exactly on the 162nd complete period. It judges the outcome by the re-initialization count going up by one and by `oe` staying low over the following frame. It then confirms that settling restarts from zero against the new reference.

// File: rtl/frame_rate_monitor.sv
module frame_rate_monitor #(
  parameter int CNT_W        = 16,
  parameter int DEV_SHIFT    = 4,
  parameter int DEV_RUN      = 8,
  parameter int SETTLE       = 162,
  parameter int STOP_TIMEOUT = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clk,
  input  logic fault_in,
  output logic reinit,
  output logic oe,
  output logic status_n
);
  localparam int LIM_W = CNT_W + 1;
  localparam int RUN_W = $clog2(DEV_RUN + 1);
  localparam int SET_W = $clog2(SETTLE + 1);

  logic [2:0]       fsync;
  logic [LIM_W-1:0] per_cnt;
  logic [CNT_W-1:0] ref_per;
  logic             ref_valid, have_edge, stopped;
  logic [RUN_W-1:0] dev_run;
  logic [SET_W-1:0] settle_cnt;

  logic             rise, complete, dev, dev_trig, stop_trig, trig;
  logic [LIM_W-1:0] limit, ref_ext, diff, thr;

  assign rise     = fsync[1] & ~fsync[2];
  assign complete = rise & have_edge;
  assign ref_ext  = {1'b0, ref_per};
  assign limit    = ref_valid ? {ref_per, 1'b0} : LIM_W'(STOP_TIMEOUT);
  assign diff     = (per_cnt > ref_ext) ? per_cnt - ref_ext : ref_ext - per_cnt;
  assign thr      = LIM_W'(ref_per >> DEV_SHIFT);
  assign dev      = diff > thr;

  assign dev_trig  = complete & ref_valid & dev & (dev_run == RUN_W'(DEV_RUN - 1));
  assign stop_trig = ~rise & ~stopped & (per_cnt >= limit);
  assign trig      = dev_trig | stop_trig;

  assign status_n = fault_in | ~oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsync      <= '0;
      per_cnt    <= '0;
      ref_per    <= '0;
      ref_valid  <= 1'b0;
      have_edge  <= 1'b0;
      stopped    <= 1'b0;
      dev_run    <= '0;
      settle_cnt <= '0;
      oe         <= 1'b0;
      reinit     <= 1'b0;
    end else begin
      fsync  <= {fsync[1:0], frame_clk};
      reinit <= trig;

      if (rise)
        per_cnt <= LIM_W'(1);
      else if (stop_trig)
        per_cnt <= '0;
      else if (per_cnt < limit)
        per_cnt <= per_cnt + 1'b1;

      if (trig) begin
        ref_valid  <= 1'b0;
        dev_run    <= '0;
        settle_cnt <= '0;
        oe         <= 1'b0;
        have_edge  <= rise;
        stopped    <= stop_trig;
      end else begin
        if (rise) begin
          have_edge <= 1'b1;
          stopped   <= 1'b0;
        end
        if (complete) begin
          if (!ref_valid) begin
            ref_per   <= per_cnt[CNT_W-1:0];
            ref_valid <= 1'b1;
            dev_run   <= '0;
          end else begin
            dev_run <= dev ? dev_run + 1'b1 : '0;
          end
          if (!oe) begin
            if (settle_cnt == SET_W'(SETTLE - 1))
              oe <= 1'b1;
            else
              settle_cnt <= settle_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/frame_rate_monitor_chk.sv
module frame_rate_monitor_chk #(
  parameter int LIM_W   = 17,
  parameter int RUN_W   = 4,
  parameter int DEV_RUN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fault_in,
  input logic             reinit,
  input logic             oe,
  input logic             status_n,
  input logic [LIM_W-1:0] per_cnt,
  input logic [LIM_W-1:0] limit,
  input logic [RUN_W-1:0] dev_run,
  input logic             ref_valid
);
  a_r1_status_in_reset: assert property (@(posedge clk) !rst_n |-> (status_n && !oe && !reinit));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> !reinit);

  a_r5_oe_low_on_reinit: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |-> !oe);

  a_r5_oe_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> ref_valid);

  a_r4_counter_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    per_cnt <= limit);

  a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    dev_run < RUN_W'(DEV_RUN));

  a_r6_fault_forces_status: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |-> status_n);
endmodule

bind frame_rate_monitor frame_rate_monitor_chk #(
  .LIM_W(LIM_W), .RUN_W(RUN_W), .DEV_RUN(DEV_RUN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .reinit(reinit), .oe(oe),
  .status_n(status_n), .per_cnt(per_cnt), .limit(limit), .dev_run(dev_run),
  .ref_valid(ref_valid)
);

// File: tb/frame_rate_monitor_tb.sv
module frame_rate_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 4000;
  localparam int NOM        = 72;

  logic clk = 1'b0, rst_n = 1'b0, frame_clk = 1'b0, fault_in = 1'b0;
  logic reinit, oe, status_n;
  int   n_checks = 0, n_errors = 0, n_reinit = 0;
  bit   done = 0;

  frame_rate_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .fault_in(fault_in),
    .reinit(reinit), .oe(oe), .status_n(status_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n && reinit) n_reinit <= n_reinit + 1;

  function automatic bit exceeds(input int refp, input int p);
    int d = (p > refp) ? p - refp : refp - p;
    return d > (refp >> 4);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input int p);
    frame_clk = 1'b1;
    repeat (p/2) @(negedge clk);
    frame_clk = 1'b0;
    repeat (p - p/2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int p, base;
    void'($urandom(32'd7321));
    idle(5);
    chk("R1 oe in reset", oe, 0);
    chk("R1 status in reset", status_n, 1);
    chk("R1 reinit in reset", reinit, 0);
    rst_n = 1'b1;

    idle(TIMEOUT - 100);
    chk("R4 no pulse before timeout", n_reinit, 0);
    idle(200);
    chk("R4 pulse at timeout", n_reinit, 1);
    idle(TIMEOUT + 500);
    chk("R4 no repeat while stopped", n_reinit, 1);

    for (int i = 0; i < 154; i++) frame(64);
    chk("R5 oe low before settled", oe, 0);
    for (int i = 0; i < 9; i++) frame(NOM);
    chk("R7 reinit on colliding edge", n_reinit, 2);
    chk("R7 oe stays low", oe, 0);

    for (int i = 0; i < 161; i++) frame(NOM);
    chk("R5 oe low one period early", oe, 0);
    chk("R6 status high when not ready", status_n, 1);
    frame(NOM);
    chk("R5 oe high after settle", oe, 1);
    chk("R6 status low when ready", status_n, 0);
    chk("R2 new reference accepted", n_reinit, 2);

    fault_in = 1'b1;
    idle(1);
    chk("R6 fault forces status", status_n, 1);
    fault_in = 1'b0;
    idle(1);
    chk("R6 status low after fault", status_n, 0);

    for (int i = 0; i < 40; i++) begin
      p = NOM - 4 + int'($urandom_range(8, 0));
      if (exceeds(NOM, p)) p = NOM;
      frame(p);
    end
    chk("R3 small jitter ignored", n_reinit, 2);
    chk("R3 oe kept under jitter", oe, 1);

    for (int i = 0; i < 8; i++) frame(NOM + 4);
    for (int i = 0; i < 8; i++) frame(NOM - 4);
    frame(NOM);
    chk("R3 equal-threshold not deviating", n_reinit, 2);

    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 7; i++) begin
        if ($urandom_range(1, 0) == 1) p = NOM + 5 + int'($urandom_range(19, 0));
        else p = NOM - 5 - int'($urandom_range(14, 0));
        if (!exceeds(NOM, p)) p = NOM + 10;
        frame(p);
      end
      frame(NOM);
      frame(NOM);
    end
    chk("R3 seven deviations ignored", n_reinit, 2);
    chk("R3 oe kept after short run", oe, 1);

    base = 90;
    for (int i = 0; i < 9; i++) frame(base);
    chk("R3 eight deviations reinit", n_reinit, 3);
    chk("R5 oe drops on reinit", oe, 0);
    for (int i = 0; i < 4; i++) frame(base);
    chk("R2 reference follows new rate", n_reinit, 3);

    frame(base);
    idle(2*base - base - 10);
    chk("R4 no stop before twice reference", n_reinit, 3);
    idle(30);
    chk("R4 stop after twice reference", n_reinit, 4);
    chk("R8 pulse low after stop", reinit, 0);
    idle(2000);
    chk("R4 single stop pulse", n_reinit, 4);
    chk("R5 oe low while stopped", oe, 0);

    for (int i = 0; i < 162; i++) frame(50);
    chk("R5 oe low after restart partial", oe, 0);
    frame(50);
    chk("R5 oe high after restart", oe, 1);
    chk("R2 restart reference stable", n_reinit, 4);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule